// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block lets a two-wire bus master read and write a 512-byte on-chip byte array. It oversamples the clock and data lines of an open-drain bus with the system clock and finds START, repeated START and STOP conditions. It receives a device-address byte and compares it with a fixed prefix and two strap inputs. When the address matches, it acknowledges and then runs either a write or a read. The output `sdaDrvLow` tells the pad to pull the data line low. The block never drives the line high.

The byte-address counter lives inside the block and is kept between transactions. A write sets the counter from a word-address byte, stores every following data byte and steps the counter after each one. A read always begins at the counter. Three read forms follow from this:
- A plain read is a current-address read.
- A random read is a write that stops after the word address, followed by a repeated START with the read flag set.
- A burst read continues for as long as the master acknowledges.

The counter spans the whole array and wraps from the last byte to byte 0.

Top module: `twi_mem_target`

## Requirements
- R1: A START (data line falls while the clock line is high) restarts device-address reception at any point, even in the middle of a byte. A STOP (data line rises while the clock line is high) returns the block to idle. After either condition the data line is released.
- R2: The device-address byte holds the following fields, sent MSB first:
  - bits 7..4: the fixed prefix 1010
  - bits 3..2: must equal `strapSel`
  - bit 1: array address bit 8
  - bit 0: read flag (1 = read)

  On a match the block pulls the data line low during the ninth clock of that byte.
- R3: A device-address byte that does not match is not acknowledged. The block then drives nothing and leaves its address counter unchanged until the next START.
- R4: In a write, the block acknowledges the word-address byte and loads the counter with {device-address bit 1, word byte}. It acknowledges and stores each following data byte at the counter, and the counter steps by one after each store.
- R5: A read returns the byte at the counter, and the counter then steps by one. The counter keeps its value across STOP, so after a last access to address n the next plain read returns byte n+1.
- R6: A random read works as follows. A write carries only the word address. It is followed by a repeated START and a matching read address, and the block returns the byte at the loaded address.
- R7: While the master acknowledges each byte (data line low in the ninth clock), the block sends the byte at the next address.
- R8: The counter covers all 9 address bits. After address 0x1FF a burst continues at address 0x000.
- R9: Data bits go out MSB first. The block changes its drive only while the clock line is low, so the driven level stays constant through each high phase.
- R10: When the master does not acknowledge a read byte, the block releases the line and ignores all further clocks until the next START.
- R11: The block releases the data line during the master's acknowledge clock after each read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapSel | input | 2 | Board-level select bits compared with device-address bits 3..2 |
| sdaDrvLow | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
The embedded properties check on every cycle that:
- the line is pulled low in each acknowledge phase;
- the line is released while idle and during the master's acknowledge clock;
- the drive changes only while the sampled clock is low;
- a START clears the bit count.

Only the directed scenarios can show that the stored and returned bytes are correct. They also cover the counter carry-over between transactions, the wrap from the top address to 0, random reads through a repeated START, and the silence that follows a mismatched address or a NACK.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WORD,
    ST_ACK_WORD,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } ctlState_e;

  typedef struct packed {
    logic clrBits;
    logic countBit;
    logic latchDev;
    logic loadWord;
    logic storeByte;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic freeSda;
  } dpStrobes_t;

endpackage

// File: rtl/twi_mem_datapath.sv
module twi_mem_datapath
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int HI_W = ADDR_W - 8,
  localparam int STRAP_W = 3 - HI_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapSel,
  input  dpStrobes_t         st,
  output logic               evStart,
  output logic               evStop,
  output logic               evRise,
  output logic               evFall,
  output logic               bitsDone,
  output logic               devMatch,
  output logic               devRead,
  output logic               rxLsb,
  output logic               sdaLow
);

  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int BIT_W = 4;
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BIT_W-1:0] bitCnt;
  logic [7:0] rxReg, txReg, memRd;
  logic [HI_W-1:0] hiSel;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0] mem [MEM_BYTES];

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign evRise  = sclS & ~sclPrev;
  assign evFall  = ~sclS & sclPrev;
  assign evStart = sclS & sclPrev & sdaPrev & ~sdaS;
  assign evStop  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign memRd    = mem[addrCnt];
  assign bitsDone = (bitCnt == BIT_W'(8));
  assign devMatch = (rxReg[7:4] == 4'b1010) && (rxReg[3:HI_W+1] == strapSel);
  assign devRead  = rxReg[0];
  assign rxLsb    = rxReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxReg   <= '0;
      txReg   <= '0;
      hiSel   <= '0;
      addrCnt <= '0;
      sdaLow  <= 1'b0;
    end else begin
      if (st.clrBits)       bitCnt <= '0;
      else if (st.countBit) bitCnt <= bitCnt + 1'b1;

      if (st.countBit) rxReg <= {rxReg[6:0], sdaS};
      if (st.latchDev) hiSel <= rxReg[HI_W:1];

      if (st.loadWord)                    addrCnt <= {hiSel, rxReg};
      else if (st.storeByte || st.loadTx) addrCnt <= addrCnt + 1'b1;

      if (st.loadTx)       txReg <= memRd;
      else if (st.shiftTx) txReg <= {txReg[6:0], 1'b0};

      if (st.freeSda)       sdaLow <= 1'b0;
      else if (st.driveAck) sdaLow <= 1'b1;
      else if (st.loadTx)   sdaLow <= ~memRd[7];
      else if (st.shiftTx)  sdaLow <= ~txReg[6];
    end
  end

  always_ff @(posedge clk) begin
    if (st.storeByte) mem[addrCnt] <= rxReg;
  end

  // R1: a START seen on the bus leaves the bit count at zero
  p_start_clears_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    evStart |=> (bitCnt == '0));

  // R9: drive level moves only while the sampled clock is low, except releases on START/STOP
  p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaLow) && !$past(evStart || evStop)) |-> !sclS);

endmodule

// File: rtl/twi_mem_control.sv
module twi_mem_control
  import twi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evRise,
  input  logic       evFall,
  input  logic       bitsDone,
  input  logic       devMatch,
  input  logic       devRead,
  input  logic       rxLsb,
  output dpStrobes_t st,
  output ctlState_e  state
);

  ctlState_e nxt;
  logic rdFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdFlag <= 1'b0;
    end else begin
      state <= nxt;
      if (st.latchDev) rdFlag <= devRead;
    end
  end

  always_comb begin
    st  = '0;
    nxt = state;
    if (evStart) begin
      nxt        = ST_DEV;
      st.clrBits = 1'b1;
      st.freeSda = 1'b1;
    end else if (evStop) begin
      nxt        = ST_IDLE;
      st.clrBits = 1'b1;
      st.freeSda = 1'b1;
    end else if (evRise) begin
      if (state != ST_IDLE) st.countBit = 1'b1;
    end else if (evFall) begin
      case (state)
        ST_DEV: if (bitsDone) begin
          if (devMatch) begin
            st.latchDev = 1'b1;
            st.driveAck = 1'b1;
            nxt         = ST_ACK_DEV;
          end else begin
            st.freeSda = 1'b1;
            nxt        = ST_IDLE;
          end
        end
        ST_ACK_DEV: begin
          st.clrBits = 1'b1;
          if (rdFlag) begin
            st.loadTx = 1'b1;
            nxt       = ST_RDATA;
          end else begin
            st.freeSda = 1'b1;
            nxt        = ST_WORD;
          end
        end
        ST_WORD: if (bitsDone) begin
          st.loadWord = 1'b1;
          st.driveAck = 1'b1;
          nxt         = ST_ACK_WORD;
        end
        ST_ACK_WORD, ST_ACK_WDATA: begin
          st.clrBits = 1'b1;
          st.freeSda = 1'b1;
          nxt        = ST_WDATA;
        end
        ST_WDATA: if (bitsDone) begin
          st.storeByte = 1'b1;
          st.driveAck  = 1'b1;
          nxt          = ST_ACK_WDATA;
        end
        ST_RDATA: begin
          if (bitsDone) begin
            st.freeSda = 1'b1;
            st.clrBits = 1'b1;
            nxt        = ST_RACK;
          end else begin
            st.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (!rxLsb) begin
            st.loadTx  = 1'b1;
            st.clrBits = 1'b1;
            nxt        = ST_RDATA;
          end else begin
            st.freeSda = 1'b1;
            nxt        = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int STRAP_W = 11 - ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapSel,
  output logic               sdaDrvLow
);

  dpStrobes_t strobes;
  ctlState_e  ctlState;
  logic evStart, evStop, evRise, evFall, bitsDone, devMatch, devRead, rxLsb;

  twi_mem_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapSel(strapSel),
    .st(strobes), .evStart(evStart), .evStop(evStop), .evRise(evRise),
    .evFall(evFall), .bitsDone(bitsDone), .devMatch(devMatch),
    .devRead(devRead), .rxLsb(rxLsb), .sdaLow(sdaDrvLow)
  );

  twi_mem_control uCtl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evRise(evRise), .evFall(evFall), .bitsDone(bitsDone),
    .devMatch(devMatch), .devRead(devRead), .rxLsb(rxLsb),
    .st(strobes), .state(ctlState)
  );

  // R2: every acknowledge phase pulls the line low
  p_ack_drives_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_ACK_DEV || ctlState == ST_ACK_WORD || ctlState == ST_ACK_WDATA)
      |-> sdaDrvLow);

  // R10: idle means the line is left alone
  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_IDLE) |-> !sdaDrvLow);

  // R11: released while the master answers a read byte
  p_master_ack_free_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_RACK) |-> !sdaDrvLow);

endmodule

// File: tb/twi_mem_target_test.sv
`timescale 1ns/100ps
module twi_mem_target_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdaDrvLow;
  logic sdaLine;
  int runs = 0;
  int fails = 0;
  bit finished = 1'b0;

  assign sdaLine = sdaM & ~sdaDrvLow;

  always #2.5 clk = ~clk;

  twi_mem_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapSel(strap), .sdaDrvLow(sdaDrvLow)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input logic hi, input logic rd);
    return {4'b1010, strap, hi, rd};
  endfunction

  task automatic startCond();
    waitClk(4); sdaM = 1'b1;
    waitClk(4); sclM = 1'b1;
    waitClk(4); sdaM = 1'b0;
    waitClk(4); sclM = 1'b0;
  endtask

  task automatic stopCond();
    waitClk(4); sdaM = 1'b0;
    waitClk(4); sclM = 1'b1;
    waitClk(4); sdaM = 1'b1;
    waitClk(4);
  endtask

  task automatic clockBit(input logic drv, output logic seen, output logic held, output logic stab);
    logic h1;
    waitClk(4); sdaM = drv;
    waitClk(4); sclM = 1'b1;
    waitClk(4); seen = sdaLine; h1 = sdaDrvLow;
    waitClk(3); stab = (sdaDrvLow == h1); held = h1;
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked, output logic quiet);
    logic seen, held, stab;
    quiet = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(b[i], seen, held, stab);
      if (held) quiet = 1'b0;
    end
    clockBit(1'b1, seen, held, stab);
    acked = ~seen;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] val, output logic stableAll, output logic freeAck);
    logic seen, held, stab;
    stableAll = 1'b1;
    val = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, seen, held, stab);
      val = {val[6:0], seen};
      if (!stab) stableAll = 1'b0;
    end
    clockBit(~mAck, seen, held, stab);
    freeAck = ~held;
  endtask

  // random-read setup: dummy write of a word address then repeated START with read flag
  task automatic setupRandom(input logic hi, input logic [7:0] word, input string tag);
    logic ak, q;
    startCond();
    sendByte(devByte(hi, 1'b0), ak, q);
    check(ak, tag, 16'(ak), 16'd1);
    sendByte(word, ak, q);
    check(ak, tag, 16'(ak), 16'd1);
    startCond();
    sendByte(devByte(hi, 1'b1), ak, q);
    check(ak, tag, 16'(ak), 16'd1);
  endtask

  task automatic t_reset();
    waitClk(3);
    check(sdaDrvLow == 1'b0, "R1 reset release", 16'(sdaDrvLow), 16'd0);
  endtask

  task automatic t_write();
    logic ak, q;
    logic [7:0] data [5] = '{8'h5A, 8'hC3, 8'h3C, 8'h96, 8'h0F};
    startCond();
    sendByte(devByte(1'b0, 1'b0), ak, q);
    check(ak, "R2 device ack", 16'(ak), 16'd1);
    sendByte(8'h10, ak, q);
    check(ak, "R4 word ack", 16'(ak), 16'd1);
    for (int i = 0; i < 5; i++) begin
      sendByte(data[i], ak, q);
      check(ak, "R4 data ack", 16'(ak), 16'd1);
    end
    stopCond();
    check(sdaDrvLow == 1'b0, "R1 stop release", 16'(sdaDrvLow), 16'd0);
  endtask

  task automatic t_random();
    logic [7:0] v; logic s, f;
    setupRandom(1'b0, 8'h11, "R6 setup ack");
    readByte(1'b0, v, s, f);
    check(v == 8'hC3, "R6 random read data", 16'(v), 16'h00C3);
    check(s, "R9 stable in high phase", 16'(s), 16'd1);
    check(f, "R11 free during master ack", 16'(f), 16'd1);
    stopCond();
  endtask

  task automatic t_current();
    logic ak, q, s, f; logic [7:0] v;
    startCond();
    sendByte(devByte(1'b0, 1'b1), ak, q);
    check(ak, "R5 read address ack", 16'(ak), 16'd1);
    readByte(1'b0, v, s, f);
    check(v == 8'h3C, "R5 current read n+1", 16'(v), 16'h003C);
    stopCond();
  endtask

  task automatic t_burst();
    logic [7:0] v; logic s, f;
    logic [7:0] exp [4] = '{8'h5A, 8'hC3, 8'h3C, 8'h96};
    setupRandom(1'b0, 8'h10, "R7 setup ack");
    for (int i = 0; i < 4; i++) begin
      readByte(i != 3, v, s, f);
      check(v == exp[i], "R7 burst data", 16'(v), 16'(exp[i]));
      check(s && f, "R11 burst release", 16'({s, f}), 16'd3);
    end
    stopCond();
  endtask

  task automatic t_mismatch();
    logic ak, q, s, f; logic [7:0] v;
    startCond();
    sendByte({4'b1010, ~strap, 1'b0, 1'b1}, ak, q);
    check(!ak, "R3 wrong strap no ack", 16'(ak), 16'd0);
    sendByte(8'h00, ak, q);
    check(!ak && q, "R3 ignored after mismatch", 16'({ak, q}), 16'd1);
    stopCond();
    startCond();
    sendByte({4'b1011, strap, 1'b0, 1'b1}, ak, q);
    check(!ak, "R3 wrong prefix no ack", 16'(ak), 16'd0);
    stopCond();
    startCond();
    sendByte(devByte(1'b0, 1'b1), ak, q);
    readByte(1'b0, v, s, f);
    check(v == 8'h0F, "R3 counter untouched", 16'(v), 16'h000F);
    stopCond();
  endtask

  task automatic t_nack_idle();
    logic ak, q, s, f; logic [7:0] v;
    setupRandom(1'b0, 8'h13, "R10 setup ack");
    readByte(1'b0, v, s, f);
    check(v == 8'h96, "R10 read before nack", 16'(v), 16'h0096);
    sendByte(8'h00, ak, q);
    check(q && !ak, "R10 silent after nack", 16'({ak, q}), 16'd1);
    stopCond();
  endtask

  task automatic t_wrap();
    logic ak, q, s, f; logic [7:0] v;
    startCond();
    sendByte(devByte(1'b1, 1'b0), ak, q);
    sendByte(8'hFF, ak, q);
    sendByte(8'hE7, ak, q);
    check(ak, "R4 upper half store ack", 16'(ak), 16'd1);
    stopCond();
    startCond();
    sendByte(devByte(1'b0, 1'b0), ak, q);
    sendByte(8'h00, ak, q);
    sendByte(8'h81, ak, q);
    stopCond();
    setupRandom(1'b1, 8'hFF, "R8 setup ack");
    readByte(1'b1, v, s, f);
    check(v == 8'hE7, "R8 top address", 16'(v), 16'h00E7);
    readByte(1'b0, v, s, f);
    check(v == 8'h81, "R8 wrap to zero", 16'(v), 16'h0081);
    stopCond();
  endtask

  task automatic t_restart();
    logic seen, held, stab; logic [7:0] v; logic s, f;
    startCond();
    for (int i = 0; i < 4; i++) clockBit(i[0], seen, held, stab);
    setupRandom(1'b0, 8'h12, "R1 restart mid byte ack");
    readByte(1'b0, v, s, f);
    check(v == 8'h3C, "R1 read after mid-byte START", 16'(v), 16'h003C);
    stopCond();
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    t_reset();
    t_write();
    t_random();
    t_current();
    t_burst();
    t_mismatch();
    t_nack_idle();
    t_wrap();
    t_restart();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

endmodule